// File: doc/BRIEF.md
# Cyclic Channel-Status and User Byte Buffer

This block sits between a host processor and a digital audio frame encoder. The host fills a 28-byte register file through an 8-bit parallel port. The transmit side walks the stored bytes over and over without erasing them. Each time a byte's first bit is due, that byte is copied into a shift register. The encoder then receives the channel-status bit, the user bit and, in one mode, an auxiliary nibble for every sub-frame.

An external one-cycle strobe marks the start of each sub-frame. Two sub-frames form a frame, and 192 frames form a block. Three position flags tell the host which part of the buffer is being sent, so it can rewrite the other part. An interrupt pulses when an enabled flag changes. A control register selects the memory mode, and it has a self-clearing bit that restarts the block.

Top module: `txbuf_cycler`

## Requirements
- R1: After reset, the status, control and mask registers read 0. `cs_bit`, `user_bit`, `aux_nib`, `flags` and `irq` are 0, and the buffer bytes read 0.
- R2: With `cs_n` low and `rd_wr` high, `rdata` shows the addressed byte. With `cs_n` low and `rd_wr` low, `wdata` is stored at the next clock edge. With `cs_n` high, `rdata` is 0 and nothing is stored. The address map is: 0 status, 1 control, 2 interrupt mask, 3 reads 0, 4..31 buffer bytes.
- R3: Channel-status byte k (k = 0..23) sits at address 8+k. It is sent LSB first, one bit per frame, with the same bit in both sub-frames. After frame 191 the sequence restarts at frame 0 from the same stored bytes.
- R4: In modes 0 and 1, user bytes sit at addresses 4..7. They are sent LSB first, one bit per sub-frame, in a 32-sub-frame cycle. In mode 2, `user_bit` is 0.
- R5: In mode 1, auxiliary byte j (j = 0..15, at address 16+j) is sent in frame j of each 16-frame cycle: the low nibble in sub-frame 0 and the high nibble in sub-frame 1. Only the first 8 channel-status bytes are sent; frames 64..191 carry channel-status 0. In the other modes, `aux_nib` is 0.
- R6: A byte is captured when its first bit goes out. A host write to that byte in the same cycle or later affects only the next pass.
- R7: Status bit 2 is high in frames 0..31. Status bit 1 is high in frames 96..191, or in frames 32..63 in mode 1. Status bit 0 is high when the frame number mod 16 is 8 or more. `flags` equals status bits [2:0], and all are 0 before the first strobe.
- R8: `irq` is high for exactly the one cycle after an edge on any flag whose mask bit (mask register bits [2:0], same order as the flags) is 1. Both rising and falling edges count.
- R9: Writing control with bit 2 set restarts the block: the next strobe sends frame 0, sub-frame 0. Bit 2 reads back 0, and control bits [1:0] set the mode.
- R10: Mode value 3 behaves as mode 0 for all outputs and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 5 | Host byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| sub_tick | input | 1 | One-cycle strobe at each sub-frame start |
| cs_bit | output | 1 | Channel-status bit for the current sub-frame |
| user_bit | output | 1 | User bit for the current sub-frame |
| aux_nib | output | 4 | Auxiliary nibble for the current sub-frame |
| flags | output | 3 | Position flags {block head, status tail, user tail} |
| irq | output | 1 | Interrupt pulse on masked flag edges |

## Verification
The transmit load of a byte and a host write to that same byte can fall on one clock edge. The bench provokes this by raising the sub-frame strobe and a write to the address of the channel-status byte whose first bit is due, in the same cycle. It expects the old value for the whole of that byte. It expects the new value on the next pass through the block.

// File: rtl/txbuf_cycler.sv
module txbuf_cycler #(
  parameter int FRAMES = 192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_wr,
  input  logic [4:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       sub_tick,
  output logic       cs_bit,
  output logic       user_bit,
  output logic [3:0] aux_nib,
  output logic [2:0] flags,
  output logic       irq
);
  localparam int NBYTES = 28;
  localparam logic [7:0] LAST = 8'(FRAMES - 1);

  logic [7:0] mem [0:NBYTES-1];
  logic [1:0] mode;
  logic [2:0] mask, flags_q;
  logic       started, sub;
  logic [7:0] frm;
  logic [7:0] cs_sr, u_sr, a_sr;

  wire host_wr = !cs_n && !rd_wr;
  wire realign = host_wr && addr == 5'd1 && wdata[2];
  wire [1:0] emode = (mode == 2'd3) ? 2'd0 : mode;
  wire wrap = frm == LAST && sub;

  logic [7:0] nfrm;
  logic       nsub;
  always_comb begin
    if (!started || wrap) begin
      nfrm = 8'd0; nsub = 1'b0;
    end else if (!sub) begin
      nfrm = frm;  nsub = 1'b1;
    end else begin
      nfrm = frm + 8'd1; nsub = 1'b0;
    end
  end

  wire [4:0] cs_ix = 5'(nfrm[7:3]) + 5'd4;
  wire [4:0] u_ix  = {3'b0, nfrm[3:2]};
  wire [4:0] a_ix  = {1'b0, nfrm[3:0]} + 5'd12;
  wire [7:0] cs_src = (emode == 2'd1 && nfrm >= 8'd64) ? 8'd0 : mem[cs_ix];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
      mode <= '0;
      mask <= '0;
    end else if (host_wr) begin
      if (addr >= 5'd4) mem[addr - 5'd4] <= wdata;
      if (addr == 5'd1) mode <= wdata[1:0];
      if (addr == 5'd2) mask <= wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      frm     <= '0;
      sub     <= 1'b0;
      cs_sr   <= '0;
      u_sr    <= '0;
      a_sr    <= '0;
    end else if (realign) begin
      started <= 1'b0;
      frm     <= '0;
      sub     <= 1'b0;
    end else if (sub_tick) begin
      started <= 1'b1;
      frm     <= nfrm;
      sub     <= nsub;
      if (!nsub && nfrm[2:0] == 3'd0) cs_sr <= cs_src;
      else if (!nsub)                 cs_sr <= {1'b0, cs_sr[7:1]};
      if ({nfrm[1:0], nsub} == 3'd0)  u_sr  <= mem[u_ix];
      else                            u_sr  <= {1'b0, u_sr[7:1]};
      if (!nsub) a_sr <= mem[a_ix];
      else       a_sr <= {4'b0, a_sr[7:4]};
    end
  end

  assign cs_bit   = cs_sr[0];
  assign user_bit = (emode == 2'd2) ? 1'b0 : u_sr[0];
  assign aux_nib  = (emode == 2'd1) ? a_sr[3:0] : 4'd0;

  assign flags[2] = started && frm < 8'd32;
  assign flags[1] = started && ((emode == 2'd1) ? (frm >= 8'd32 && frm < 8'd64) : frm >= 8'd96);
  assign flags[0] = started && frm[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags;
  end

  assign irq = |((flags ^ flags_q) & mask);

  always_comb begin
    rdata = 8'd0;
    if (!cs_n && rd_wr) begin
      case (addr)
        5'd0:    rdata = {5'd0, flags};
        5'd1:    rdata = {6'd0, mode};
        5'd2:    rdata = {5'd0, mask};
        5'd3:    rdata = 8'd0;
        default: rdata = mem[addr - 5'd4];
      endcase
    end
  end

  assert_pos_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_tick && !realign) |=> ($stable(frm) && $stable(sub)));

  assert_block_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_tick && !realign && started && frm == LAST && sub) |=> (frm == 8'd0 && !sub));

  assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags[2] && flags[1]));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != 3'd0));

  assert_realign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (!started && flags == 3'd0));
endmodule

// File: tb/sim_txbuf_cycler.sv
`timescale 1ns/1ps
module sim_txbuf_cycler;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rd_wr = 1, sub_tick = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic cs_bit, user_bit, irq;
  logic [3:0] aux_nib;
  logic [2:0] flags;

  always #2 clk = ~clk;

  txbuf_cycler u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sub_tick(sub_tick), .cs_bit(cs_bit),
    .user_bit(user_bit), .aux_nib(aux_nib), .flags(flags), .irq(irq));

  typedef struct packed {
    logic       c;
    logic       u;
    logic [3:0] a;
    logic [2:0] f;
    logic       i;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_mem [0:31];
  logic [1:0] m_mode = 0;
  logic [2:0] m_mask = 0, m_fl = 0;
  bit         m_started = 0, m_s = 0;
  int         m_f = 0;
  logic [7:0] m_cs = 0, m_u = 0, m_a = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] em();
    return (m_mode == 2'd3) ? 2'd0 : m_mode;
  endfunction

  function automatic logic [2:0] mdl_flags();
    logic [2:0] f;
    f[2] = m_started && m_f < 32;
    f[1] = m_started && ((em() == 2'd1) ? (m_f >= 32 && m_f < 64) : m_f >= 96);
    f[0] = m_started && ((m_f % 16) >= 8);
    return f;
  endfunction

  task automatic mdl_tick();
    exp_t e;
    logic [2:0] nf;
    if (!m_started || (m_f == 191 && m_s)) begin m_f = 0; m_s = 0; end
    else if (!m_s) m_s = 1;
    else begin m_f = m_f + 1; m_s = 0; end
    m_started = 1;
    if (!m_s && m_f % 8 == 0) m_cs = (em() == 2'd1 && m_f >= 64) ? 8'd0 : m_mem[8 + m_f / 8];
    else if (!m_s) m_cs = m_cs >> 1;
    if (!m_s && m_f % 4 == 0) m_u = m_mem[4 + (m_f % 16) / 4];
    else m_u = m_u >> 1;
    if (!m_s) m_a = m_mem[16 + m_f % 16];
    else m_a = m_a >> 4;
    nf = mdl_flags();
    e.c = m_cs[0];
    e.u = (em() == 2'd2) ? 1'b0 : m_u[0];
    e.a = (em() == 2'd1) ? m_a[3:0] : 4'd0;
    e.f = nf;
    e.i = |((nf ^ m_fl) & m_mask);
    m_fl = nf;
    exp_q.push_back(e);
  endtask

  task automatic mdl_write(input logic [4:0] a, input logic [7:0] d);
    if (a >= 4) m_mem[a] = d;
    if (a == 1) begin
      m_mode = d[1:0];
      if (d[2]) begin m_started = 0; m_f = 0; m_s = 0; end
      m_fl = mdl_flags();
    end
    if (a == 2) m_mask = d[2:0];
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cs_n = 0; rd_wr = 0; addr = a; wdata = d;
    @(posedge clk); #1;
    cs_n = 1; rd_wr = 1;
    mdl_write(a, d);
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    cs_n = 0; rd_wr = 1; addr = a;
    @(negedge clk);
    d = rdata;
    @(posedge clk); #1;
    cs_n = 1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    sub_tick = 1;
    mdl_tick();
    @(posedge clk); #1;
    sub_tick = 0;
  endtask

  // R6: strobe and host write on the same edge
  task automatic tick_wr(input logic [4:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    sub_tick = 1; cs_n = 0; rd_wr = 0; addr = a; wdata = d;
    mdl_tick();
    mdl_write(a, d);
    @(posedge clk); #1;
    sub_tick = 0; cs_n = 1; rd_wr = 1;
  endtask

  always @(negedge clk) begin
    if (!sub_tick && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk("R3 cs_bit", cs_bit, e.c);
      chk("R4 user_bit", user_bit, e.u);
      chk("R5 aux_nib", aux_nib, e.a);
      chk("R7 flags", flags, e.f);
      chk("R8 irq", irq, e.i);
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 32; i++) m_mem[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_bit", cs_bit, 0);
    chk("R1 user_bit", user_bit, 0);
    chk("R1 aux_nib", aux_nib, 0);
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
    rd(5'd0, d); chk("R1 status", d, 0);
    rd(5'd1, d); chk("R1 control", d, 0);
    rd(5'd2, d); chk("R1 mask", d, 0);
    rd(5'd20, d); chk("R1 buffer", d, 0);

    // R2 host port
    for (int a = 4; a < 32; a++) wr(5'(a), 8'((a * 29 + 3) ^ 8'h5a));
    rd(5'd4, d);  chk("R2 readback 4", d, m_mem[4]);
    rd(5'd17, d); chk("R2 readback 17", d, m_mem[17]);
    rd(5'd31, d); chk("R2 readback 31", d, m_mem[31]);
    @(posedge clk); #1;
    cs_n = 1; rd_wr = 0; addr = 5'd10; wdata = 8'hee;
    @(negedge clk); chk("R2 deselected rdata", rdata, 0);
    @(posedge clk); #1; rd_wr = 1;
    rd(5'd10, d); chk("R2 deselected write ignored", d, m_mem[10]);
    rd(5'd3, d); chk("R2 addr3 zero", d, 0);

    // R3 R4 R7 R8: mode 0, two full blocks, R6 collision in frame 8
    wr(5'd2, 8'd7);
    rd(5'd2, d); chk("R2 mask readback", d, 7);
    for (int t = 0; t < 384; t++) begin
      if (t == 16) tick_wr(5'd9, 8'ha5);
      else tick();
    end
    for (int t = 0; t < 384; t++) tick();
    rd(5'd0, d); chk("R7 status reg", d, {5'd0, m_fl});

    // R9 realign into mode 1, R5 aux
    wr(5'd1, 8'b101);
    rd(5'd1, d); chk("R9 control reads mode only", d, 1);
    chk("R9 flags cleared", flags, 0);
    for (int t = 0; t < 200; t++) tick();

    // R4 mode 2 user silent
    wr(5'd1, 8'b110);
    for (int t = 0; t < 80; t++) tick();

    // R10 mode 3 as mode 0, realign mid-stream
    wr(5'd1, 8'b111);
    for (int t = 0; t < 70; t++) tick();
    wr(5'd1, 8'b111);
    for (int t = 0; t < 40; t++) tick();

    // R8 masked off
    wr(5'd2, 8'd0);
    wr(5'd1, 8'b100);
    for (int t = 0; t < 64; t++) tick();
    // R8 single flag enabled
    wr(5'd2, 8'd1);
    for (int t = 0; t < 64; t++) tick();

    repeat (4) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule